// File: doc/BRIEF.md
# Network Wake Event Controller

This block is the power-management corner of a network interface. Software sets an enable flag and a two-bit device power state through a small register port. Three detectors outside the block each send a one-cycle pulse: one for a magic packet, one for a wake-up frame and one for a link state change. The block raises a wake request when an event arrives while power management is enabled, the device is in a low-power state (D1, D2 or D3), and that event type is not disabled.

An accepted event sets two sticky flags. One is the power-management wake status and the other is the interrupt-cause flag in the main status register. While either flag is set, an active-low interrupt line is held low and an active-high wake pin is held high. Software clears each flag by writing 1 to it. A configuration register can turn off magic-packet wakes, turn off link-change wakes, or turn off the whole wake function.

Top module: `wake_event_ctrl`

## Requirements
- R1: After synchronous reset, every register field reads 0 (state D0, enable off, all disables off, both flags clear), `irq_n` is 1 and `wake` is 0.
- R2: Address 0 holds the power state in bits [1:0] (0=D0, 1=D1, 2=D2, 3=D3) and the enable in bit 8. Address 2 holds magic-off in bit 0, link-off in bit 1 and all-off in bit 2. Written values read back on `rd_data` in the next cycle; any other address reads 0.
- R3: A pulse that is accepted (enable = 1, state D1..D3, not disabled) at clock edge k sets address 0 bit 15 and address 1 bit 0. From edge k onward, `wake` is 1 and `irq_n` is 0.
- R4: An event that arrives while the state is D0 or the enable is 0 sets no flag and leaves `wake` at 0 and `irq_n` at 1.
- R5: Magic-off suppresses only magic-packet events and link-off suppresses only link-change events. Wake-up frame events have no per-source disable.
- R6: All-off suppresses all three event sources.
- R7: Writing 1 to address 0 bit 15 clears the wake status, and writing 1 to address 1 bit 0 clears the interrupt flag. Writing 0 to either bit leaves that flag unchanged.
- R8: `irq_n` stays low and `wake` stays high until both flags are clear.
- R9: If an accepted event and a clearing write land on the same edge, the flag remains set.
- R10: The flags do not depend on the power state. Moving to D0 or clearing the enable does not clear a flag that is already set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Write data |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | DATA_W | Read data (combinational) |
| ev_magic | input | 1 | Magic packet detected pulse |
| ev_frame | input | 1 | Wake-up frame detected pulse |
| ev_link | input | 1 | Link state change pulse |
| irq_n | output | 1 | Interrupt request, active low |
| wake | output | 1 | Wake pin, active high |

## Verification
A wrong gating term shows up one clock after the offending pulse: either `wake` rises when it should stay low, or a flag fails to read back as set. A lost or stuck flag appears at the ports on the next edge after a clear, because `irq_n` and `wake` are driven straight from the two flags. The sweep walks every combination of power state, enable, disable setting and event source. Directed cases cover partial clears, a clear that coincides with an event, and state changes made while a flag is set.

// File: rtl/wake_pkg.sv
package wake_pkg;

    typedef enum logic [1:0] {
        PWR_D0 = 2'd0,
        PWR_D1 = 2'd1,
        PWR_D2 = 2'd2,
        PWR_D3 = 2'd3
    } pwr_state_e;

    typedef struct packed {
        logic       en;
        pwr_state_e st;
    } pm_ctl_t;

    typedef struct packed {
        logic all_off;
        logic link_off;
        logic magic_off;
    } wake_cfg_t;

    localparam int NUM_SRC   = 3;
    localparam int SRC_MAGIC = 0;
    localparam int SRC_FRAME = 1;
    localparam int SRC_LINK  = 2;

    localparam int REG_PMCTL = 0;
    localparam int REG_EVSTS = 1;
    localparam int REG_WKCFG = 2;

    localparam int BIT_ST_LO  = 0;
    localparam int BIT_EN     = 8;
    localparam int BIT_PMSTS  = 15;
    localparam int BIT_INTSTS = 0;
    localparam int BIT_MAGOFF = 0;
    localparam int BIT_LNKOFF = 1;
    localparam int BIT_ALLOFF = 2;

    function automatic logic is_low_power(input pwr_state_e s);
        return s != PWR_D0;
    endfunction

    function automatic logic [NUM_SRC-1:0] src_mask(input wake_cfg_t c);
        logic [NUM_SRC-1:0] m;
        m = '0;
        m[SRC_MAGIC] = c.magic_off;
        m[SRC_LINK]  = c.link_off;
        return m;
    endfunction

endpackage

// File: rtl/wake_regs.sv
module wake_regs
    import wake_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              pm_sts,
    input  logic              int_sts,
    output logic [DATA_W-1:0] rd_data,
    output pm_ctl_t           pm_ctl,
    output wake_cfg_t         cfg,
    output logic              clr_pm,
    output logic              clr_int
);

    logic sel_pm, sel_ev, sel_cfg;

    assign sel_pm  = wr_en && (wr_addr == ADDR_W'(REG_PMCTL));
    assign sel_ev  = wr_en && (wr_addr == ADDR_W'(REG_EVSTS));
    assign sel_cfg = wr_en && (wr_addr == ADDR_W'(REG_WKCFG));

    assign clr_pm  = sel_pm && wr_data[BIT_PMSTS];
    assign clr_int = sel_ev && wr_data[BIT_INTSTS];

    always_ff @(posedge clk) begin
        if (rst) begin
            pm_ctl <= '{en: 1'b0, st: PWR_D0};
            cfg    <= '0;
        end else begin
            if (sel_pm) begin
                pm_ctl.en <= wr_data[BIT_EN];
                pm_ctl.st <= pwr_state_e'(wr_data[BIT_ST_LO +: 2]);
            end
            if (sel_cfg) begin
                cfg.magic_off <= wr_data[BIT_MAGOFF];
                cfg.link_off  <= wr_data[BIT_LNKOFF];
                cfg.all_off   <= wr_data[BIT_ALLOFF];
            end
        end
    end

    always_comb begin
        rd_data = '0;
        case (rd_addr)
            ADDR_W'(REG_PMCTL): begin
                rd_data[BIT_ST_LO +: 2] = pm_ctl.st;
                rd_data[BIT_EN]         = pm_ctl.en;
                rd_data[BIT_PMSTS]      = pm_sts;
            end
            ADDR_W'(REG_EVSTS): rd_data[BIT_INTSTS] = int_sts;
            ADDR_W'(REG_WKCFG): begin
                rd_data[BIT_MAGOFF] = cfg.magic_off;
                rd_data[BIT_LNKOFF] = cfg.link_off;
                rd_data[BIT_ALLOFF] = cfg.all_off;
            end
            default: rd_data = '0;
        endcase
    end

    logic unused_wr_bits;
    assign unused_wr_bits = ^wr_data;

endmodule

// File: rtl/wake_gate.sv
module wake_gate
    import wake_pkg::*;
(
    input  logic [NUM_SRC-1:0] ev,
    input  pm_ctl_t            pm_ctl,
    input  wake_cfg_t          cfg,
    output logic               hit
);

    logic [NUM_SRC-1:0] mask;
    logic [NUM_SRC-1:0] pass;
    logic               armed;

    assign mask  = src_mask(cfg);
    assign armed = pm_ctl.en && is_low_power(pm_ctl.st) && !cfg.all_off;

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        assign pass[i] = ev[i] && !mask[i];
    end

    assign hit = armed && (|pass);

endmodule

// File: rtl/wake_status.sv
module wake_status (
    input  logic clk,
    input  logic rst,
    input  logic hit,
    input  logic clr_pm,
    input  logic clr_int,
    output logic pm_sts,
    output logic int_sts,
    output logic irq_n,
    output logic wake
);

    always_ff @(posedge clk) begin
        if (rst) begin
            pm_sts  <= 1'b0;
            int_sts <= 1'b0;
        end else begin
            pm_sts  <= hit || (pm_sts && !clr_pm);
            int_sts <= hit || (int_sts && !clr_int);
        end
    end

    assign wake  = pm_sts || int_sts;
    assign irq_n = !(pm_sts || int_sts);

endmodule

// File: rtl/wake_event_ctrl.sv
module wake_event_ctrl
    import wake_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              ev_magic,
    input  logic              ev_frame,
    input  logic              ev_link,
    output logic              irq_n,
    output logic              wake
);

    pm_ctl_t            pm_ctl;
    wake_cfg_t          cfg;
    logic               clr_pm, clr_int, pm_sts, int_sts, hit;
    logic [NUM_SRC-1:0] ev_vec;
    logic [1:0]         pm_st_w;
    logic               pm_en_w, dis_all_w, dis_mag_w, dis_lnk_w;

    assign ev_vec[SRC_MAGIC] = ev_magic;
    assign ev_vec[SRC_FRAME] = ev_frame;
    assign ev_vec[SRC_LINK]  = ev_link;

    assign pm_st_w   = pm_ctl.st;
    assign pm_en_w   = pm_ctl.en;
    assign dis_all_w = cfg.all_off;
    assign dis_mag_w = cfg.magic_off;
    assign dis_lnk_w = cfg.link_off;

    wake_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .pm_sts(pm_sts),
        .int_sts(int_sts), .rd_data(rd_data), .pm_ctl(pm_ctl),
        .cfg(cfg), .clr_pm(clr_pm), .clr_int(clr_int)
    );

    wake_gate u_gate (
        .ev(ev_vec), .pm_ctl(pm_ctl), .cfg(cfg), .hit(hit)
    );

    wake_status u_sts (
        .clk(clk), .rst(rst), .hit(hit), .clr_pm(clr_pm),
        .clr_int(clr_int), .pm_sts(pm_sts), .int_sts(int_sts),
        .irq_n(irq_n), .wake(wake)
    );

endmodule

// File: rtl/wake_event_ctrl_chk.sv
module wake_event_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic       wr_en,
    input logic       ev_magic,
    input logic       ev_frame,
    input logic       ev_link,
    input logic       irq_n,
    input logic       wake,
    input logic       pm_en,
    input logic [1:0] pm_st,
    input logic       dis_all,
    input logic       dis_mag,
    input logic       dis_lnk
);

    logic armed;
    assign armed = pm_en && (pm_st != 2'd0) && !dis_all;

    AST_RESET_IDLE: assert property (@(posedge clk)
        $fell(rst) |-> (irq_n && !wake)); // R1

    AST_FRAME_WAKES: assert property (@(posedge clk) disable iff (rst)
        (ev_frame && armed) |=> (wake && !irq_n)); // R3

    AST_D0_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (!wake && (!pm_en || pm_st == 2'd0)) |=> !wake); // R4

    AST_MAGIC_WAKES: assert property (@(posedge clk) disable iff (rst)
        (ev_magic && !dis_mag && armed) |=> wake); // R5

    AST_LINK_BLOCKED: assert property (@(posedge clk) disable iff (rst)
        (!wake && dis_lnk && ev_link && !ev_magic && !ev_frame) |=> !wake); // R5

    AST_ALL_OFF: assert property (@(posedge clk) disable iff (rst)
        (!wake && dis_all) |=> !wake); // R6

    AST_WAKE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (wake && !wr_en) |=> (wake && !irq_n)); // R8

endmodule

bind wake_event_ctrl wake_event_ctrl_chk u_chk (
    .clk(clk), .rst(rst), .wr_en(wr_en), .ev_magic(ev_magic),
    .ev_frame(ev_frame), .ev_link(ev_link), .irq_n(irq_n), .wake(wake),
    .pm_en(pm_en_w), .pm_st(pm_st_w), .dis_all(dis_all_w),
    .dis_mag(dis_mag_w), .dis_lnk(dis_lnk_w)
);

// File: tb/test_wake_event_ctrl.sv
module test_wake_event_ctrl;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [1:0]  rd_addr = '0;
    logic [15:0] rd_data;
    logic        ev_magic = 1'b0, ev_frame = 1'b0, ev_link = 1'b0;
    logic        irq_n, wake;

    int n_cmp = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    wake_event_ctrl i_wake_event_ctrl (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .ev_magic(ev_magic), .ev_frame(ev_frame), .ev_link(ev_link),
        .irq_n(irq_n), .wake(wake)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pulse(input int src);
        @(negedge clk);
        ev_magic = (src == 0); ev_frame = (src == 1); ev_link = (src == 2);
        @(negedge clk);
        ev_magic = 1'b0; ev_frame = 1'b0; ev_link = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic clear_all();
        wr(2'd0, 16'h8000);
        wr(2'd1, 16'h0001);
    endtask

    logic [15:0] v;

    initial begin : watchdog
        #1600000;
        n_cmp++; n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 irq_n", {15'd0, irq_n}, 16'd1);
        chk("R1 wake", {15'd0, wake}, 16'd0);
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), v);
            chk("R1 reg", v, 16'd0);
        end
        // R2 unmapped address reads 0
        wr(2'd3, 16'hFFFF);
        rd(2'd3, v);
        chk("R2 unmapped", v, 16'd0);

        // Sweep: R2 R3 R4 R5 R6 R7
        for (int st = 0; st < 4; st++)
            for (int en = 0; en < 2; en++)
                for (int cf = 0; cf < 8; cf++)
                    for (int src = 0; src < 3; src++) begin
                        logic exp;
                        clear_all();
                        wr(2'd2, 16'(cf));
                        wr(2'd0, 16'((en << 8) | st));
                        rd(2'd0, v);
                        chk("R2 pmctl fields", v & 16'h0103, 16'((en << 8) | st));
                        rd(2'd2, v);
                        chk("R2 cfg fields", v, 16'(cf));
                        pulse(src);
                        exp = (en == 1) && (st != 0) && !cf[2]
                              && !(src == 0 && cf[0]) && !(src == 2 && cf[1]);
                        chk("R3/R4/R5/R6 wake", {15'd0, wake}, {15'd0, exp});
                        chk("R3 irq_n", {15'd0, irq_n}, {15'd0, !exp});
                        rd(2'd0, v);
                        chk("R3 pm status", {15'd0, v[15]}, {15'd0, exp});
                        rd(2'd1, v);
                        chk("R3 int status", v, {15'd0, exp});
                    end

        // R7 / R8: partial clears
        clear_all();
        wr(2'd2, 16'd0);
        wr(2'd0, 16'h0102);
        pulse(1);
        wr(2'd0, 16'h0102);          // bit15 = 0: no clear
        rd(2'd0, v);
        chk("R7 write0 keeps pm", {15'd0, v[15]}, 16'd1);
        wr(2'd1, 16'h0000);
        rd(2'd1, v);
        chk("R7 write0 keeps int", v, 16'd1);
        wr(2'd0, 16'h8102);
        rd(2'd0, v);
        chk("R7 pm cleared", {15'd0, v[15]}, 16'd0);
        chk("R8 wake held", {15'd0, wake}, 16'd1);
        chk("R8 irq held", {15'd0, irq_n}, 16'd0);
        wr(2'd1, 16'h0001);
        rd(2'd1, v);
        chk("R7 int cleared", v, 16'd0);
        chk("R8 wake released", {15'd0, wake}, 16'd0);
        chk("R8 irq released", {15'd0, irq_n}, 16'd1);

        // R9: event and clear on the same edge
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 2'd0; wr_data = 16'h8103; ev_link = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; ev_link = 1'b0;
        rd(2'd0, v);
        chk("R9 set wins pm", {15'd0, v[15]}, 16'd1);
        chk("R9 wake", {15'd0, wake}, 16'd1);

        // R10: leaving low power keeps the flags
        wr(2'd0, 16'h0000);
        rd(2'd0, v);
        chk("R10 pm kept in D0", v, 16'h8000);
        rd(2'd1, v);
        chk("R10 int kept", v, 16'd1);
        chk("R10 wake kept", {15'd0, wake}, 16'd1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule